// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block routes up to 24 external interrupt lines to a single delivery port. Software reaches its internal registers through two 32-bit bus locations. It first writes an internal register number into a selector, and then reads or writes the chosen register through a data window. The internal set holds these registers:

- a writable block identifier;
- a read-only version word;
- an arbitration word that always reads zero;
- one two-word routing entry per interrupt line.

A rising edge on an interrupt line is latched as pending only if that line's entry is unmasked. Pending lines are issued one at a time on a valid/ready delivery port, lowest line number first. Each request carries the vector and the decoded routing fields of its entry. A masked line produces no request at all. A line held high produces a single request, because only edges are detected.

Top module: `intr_router`

## Requirements
- R1: The selector sits at byte offset 0x00 and the data window at byte offset 0x10. A read of the selector returns the stored 8-bit register number in bits 7:0, with zeros above. A read of any other offset returns 0, and a write to any other offset changes nothing.
- R2: Internal register 0 keeps the identifier written in bits 31:24. Its bits 23:0 always read 0.
- R3: Internal register 1 always reads 0x0017_0011. This is 0x11 in bits 7:0 and the highest line index (23) in bits 23:16, and writes do not change it. Internal register 2 always reads 0.
- R4: Internal registers 0x10+2n and 0x10+2n+1 are the low word and the high word of line n's entry. Each word reads back the full 32-bit value last written to it.
- R5: After reset, every low word reads 0x0001_0000 (only the mask, bit 16, is set), every high word reads 0, the identifier reads 0, the selector reads 0 and no request is valid.
- R6: A rising edge on an unmasked line n produces exactly one request. Its vector is bits 7:0 of entry n's low word. With ready held high, req_valid rises on the second clock edge after the line is first sampled high, and it is valid for one cycle.
- R7: A rising edge on a line whose low-word bit 16 is set produces no request. A line that stays high produces no further request after its first.
- R8: A read of an internal register number outside 0–2 and 0x10–0x3F returns 0, and a write to one has no effect.
- R9: When several unmasked lines rise in the same cycle, the lowest-numbered line is issued first. The others stay pending and are issued later in ascending order.
- R10: While req_valid is high and req_ready is low, the request stays valid with all its fields unchanged.
- R11: A request also carries these fields:
  - the delivery mode from low-word bits 10:8;
  - the destination mode from bit 11;
  - the trigger select from bit 15;
  - the destination from high-word bits 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe; data appears on bus_rdata after the next edge |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 24 | Interrupt lines, one per entry |
| req_valid | output | 1 | Delivery request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_vector | output | 8 | Vector of the issued entry |
| req_dmode | output | 3 | Delivery mode of the issued entry |
| req_logical | output | 1 | Destination mode of the issued entry |
| req_level | output | 1 | Trigger select of the issued entry |
| req_dest | output | 8 | Destination of the issued entry |

## Verification
On every cycle the assertions check the following:

- reads of the version word, the identifier's low bits, undefined register numbers and unused offsets return the fixed values;
- a stalled request holds still;
- grants are one-hot and go only to pending lines;
- the port goes idle when nothing is pending.

Only the bench scenarios can show the rest:

- that masking suppresses a request;
- that a held line yields a single request;
- the ascending issue order after simultaneous edges;
- that each request's fields match what software wrote to that line's entry.

// File: rtl/intr_router_pkg.sv
package intr_router_pkg;

    localparam int OFS_SELECT = 'h00;
    localparam int OFS_WINDOW = 'h10;

    localparam logic [7:0] REG_IDENT   = 8'h00;
    localparam logic [7:0] REG_VERSION = 8'h01;
    localparam logic [7:0] REG_ARBIT   = 8'h02;
    localparam logic [7:0] TBL_BASE    = 8'h10;

    localparam logic [7:0]  VERSION_CODE = 8'h11;
    localparam int          MASK_BIT     = 16;
    localparam logic [31:0] LOW_RESET    = 32'h0001_0000;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] dmode;
        logic       logical;
        logic       level;
        logic [7:0] dest;
    } dlv_t;

    function automatic dlv_t decode_entry(input logic [31:0] lo, input logic [31:0] hi);
        dlv_t r;
        r.vector  = lo[7:0];
        r.dmode   = lo[10:8];
        r.logical = lo[11];
        r.level   = lo[15];
        r.dest    = hi[31:24];
        return r;
    endfunction

endpackage

// File: rtl/intr_router_regs.sv
module intr_router_regs
    import intr_router_pkg::*;
#(
    parameter int N_LINES = 24,
    parameter int ADDR_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic [N_LINES-1:0][31:0]   lo_words,
    output logic [N_LINES-1:0][31:0]   hi_words
);

    localparam int          IW         = $clog2(N_LINES);
    localparam logic [7:0]  TBL_END    = 8'(16 + 2 * N_LINES);
    localparam logic [31:0] VER_WORD   = {8'h00, 8'(N_LINES - 1), 8'h00, VERSION_CODE};
    localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(OFS_SELECT);
    localparam logic [ADDR_W-1:0] A_WIN = ADDR_W'(OFS_WINDOW);

    typedef struct packed {
        logic [7:0]                   sel;
        logic [7:0]                   ident;
        logic [N_LINES-1:0][31:0]     lo;
        logic [N_LINES-1:0][31:0]     hi;
        logic [31:0]                  rdata;
    } regs_st_t;

    regs_st_t st_d, st_q;

    logic          in_tbl;
    logic [7:0]    tbl_off;
    logic [IW-1:0] ent;
    logic          upper;
    logic [31:0]   win_val;

    always_comb begin
        in_tbl  = (st_q.sel >= TBL_BASE) && (st_q.sel < TBL_END);
        tbl_off = st_q.sel - TBL_BASE;
        ent     = IW'(tbl_off >> 1);
        upper   = tbl_off[0];

        win_val = 32'h0;
        if (st_q.sel == REG_IDENT) begin
            win_val = {st_q.ident, 24'h0};
        end else if (st_q.sel == REG_VERSION) begin
            win_val = VER_WORD;
        end else if (st_q.sel == REG_ARBIT) begin
            win_val = 32'h0;
        end else if (in_tbl) begin
            win_val = upper ? st_q.hi[ent] : st_q.lo[ent];
        end

        st_d = st_q;
        if (bus_wr) begin
            if (bus_addr == A_SEL) begin
                st_d.sel = bus_wdata[7:0];
            end else if (bus_addr == A_WIN) begin
                if (st_q.sel == REG_IDENT) begin
                    st_d.ident = bus_wdata[31:24];
                end else if (in_tbl) begin
                    if (upper) st_d.hi[ent] = bus_wdata;
                    else       st_d.lo[ent] = bus_wdata;
                end
            end
        end
        if (bus_rd) begin
            if (bus_addr == A_SEL)      st_d.rdata = {24'h0, st_q.sel};
            else if (bus_addr == A_WIN) st_d.rdata = win_val;
            else                        st_d.rdata = 32'h0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel   <= 8'h0;
            st_q.ident <= 8'h0;
            st_q.rdata <= 32'h0;
            for (int i = 0; i < N_LINES; i++) begin
                st_q.lo[i] <= LOW_RESET;
                st_q.hi[i] <= 32'h0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign lo_words  = st_q.lo;
    assign hi_words  = st_q.hi;

    // R3: version word is fixed
    a_r3_version_word: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_WIN && st_q.sel == REG_VERSION) |=> (bus_rdata == VER_WORD));

    // R2: identifier low bits read zero
    a_r2_ident_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_WIN && st_q.sel == REG_IDENT) |=> (bus_rdata[23:0] == 24'h0));

    // R8: undefined register numbers read zero
    a_r8_undefined_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_WIN && st_q.sel > REG_ARBIT &&
         (st_q.sel < TBL_BASE || st_q.sel >= TBL_END)) |=> (bus_rdata == 32'h0));

    // R1: unused offsets read zero
    a_r1_other_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != A_SEL && bus_addr != A_WIN) |=> (bus_rdata == 32'h0));

endmodule

// File: rtl/intr_router_edge.sv
module intr_router_edge #(
    parameter int N_LINES = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic [N_LINES-1:0] masked,
    input  logic [N_LINES-1:0] grant,
    output logic [N_LINES-1:0] pend
);

    typedef struct packed {
        logic [N_LINES-1:0] prev;
        logic [N_LINES-1:0] pend;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic [N_LINES-1:0] rise;

    always_comb begin
        rise      = irq_in & ~st_q.prev;
        st_d      = st_q;
        st_d.prev = irq_in;
        st_d.pend = (st_q.pend & ~grant) | (rise & ~masked);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

    // R9: arbiter grants only lines that are pending
    a_r9_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~st_q.pend) == '0));

endmodule

// File: rtl/intr_router_arb.sv
module intr_router_arb
    import intr_router_pkg::*;
#(
    parameter int N_LINES = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_LINES-1:0]       pend,
    input  logic [N_LINES-1:0][31:0] lo_words,
    input  logic [N_LINES-1:0][31:0] hi_words,
    input  logic                     req_ready,
    output logic [N_LINES-1:0]       grant,
    output logic                     req_valid,
    output dlv_t                     req_info
);

    localparam int IW = $clog2(N_LINES);

    typedef struct packed {
        logic valid;
        dlv_t info;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic          take;
    logic          hit;
    logic [IW-1:0] pick;

    always_comb begin
        take = !st_q.valid || req_ready;
        hit  = 1'b0;
        pick = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                hit  = 1'b1;
                pick = IW'(i);
            end
        end

        grant = '0;
        st_d  = st_q;
        if (take) begin
            st_d.valid = hit;
            if (hit) begin
                grant[pick] = 1'b1;
                st_d.info   = decode_entry(lo_words[pick], hi_words[pick]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_valid = st_q.valid;
    assign req_info  = st_q.info;

    // R10: stalled request holds
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_info)));

    // R9: at most one line granted per cycle
    a_r9_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R6: no request appears without a pending line
    a_r6_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        ((!req_valid || req_ready) && pend == '0) |=> !req_valid);

endmodule

// File: rtl/intr_router.sv
module intr_router
    import intr_router_pkg::*;
#(
    parameter int N_LINES = 24,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [N_LINES-1:0] irq_in,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [7:0]         req_vector,
    output logic [2:0]         req_dmode,
    output logic               req_logical,
    output logic               req_level,
    output logic [7:0]         req_dest
);

    logic [N_LINES-1:0][31:0] lo_words;
    logic [N_LINES-1:0][31:0] hi_words;
    logic [N_LINES-1:0]       masked;
    logic [N_LINES-1:0]       pend;
    logic [N_LINES-1:0]       grant;
    dlv_t                     info;

    for (genvar g = 0; g < N_LINES; g++) begin : g_mask
        assign masked[g] = lo_words[g][MASK_BIT];
    end

    intr_router_regs #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lo_words(lo_words), .hi_words(hi_words)
    );

    intr_router_edge #(.N_LINES(N_LINES)) edge_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .masked(masked), .grant(grant), .pend(pend)
    );

    intr_router_arb #(.N_LINES(N_LINES)) arb_i (
        .clk(clk), .rst_n(rst_n), .pend(pend),
        .lo_words(lo_words), .hi_words(hi_words),
        .req_ready(req_ready), .grant(grant),
        .req_valid(req_valid), .req_info(info)
    );

    assign req_vector  = info.vector;
    assign req_dmode   = info.dmode;
    assign req_logical = info.logical;
    assign req_level   = info.level;
    assign req_dest    = info.dest;

endmodule

// File: tb/intr_router_tb_top.sv
module intr_router_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [23:0] irq_in = '0;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [7:0]  req_vector;
    logic [2:0]  req_dmode;
    logic        req_logical;
    logic        req_level;
    logic [7:0]  req_dest;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    intr_router dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .req_valid(req_valid), .req_ready(req_ready),
        .req_vector(req_vector), .req_dmode(req_dmode),
        .req_logical(req_logical), .req_level(req_level), .req_dest(req_dest)
    );

    typedef struct packed {
        logic [7:0]  line;
        logic [31:0] low;
        logic [7:0]  exp_cnt;
        logic [7:0]  exp_vec;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'd0,  32'h0000_0020, 8'd1, 8'h20},
        '{8'd23, 32'h0000_00FE, 8'd1, 8'hFE},
        '{8'd5,  32'h0001_0055, 8'd0, 8'h00},
        '{8'd12, 32'h0000_0081, 8'd1, 8'h81},
        '{8'd12, 32'h0001_0081, 8'd0, 8'h00},
        '{8'd17, 32'h0001_8010, 8'd0, 8'h00}
    };

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic reg_write(input logic [7:0] r, input logic [31:0] d);
        bus_write(8'h00, {24'h0, r});
        bus_write(8'h10, d);
    endtask

    task automatic reg_read(input logic [7:0] r, output logic [31:0] d);
        bus_write(8'h00, {24'h0, r});
        bus_read(8'h10, d);
    endtask

    // raise a line, hold it high, count requests, then drop it
    task automatic pulse(input int line, output int cnt, output logic [7:0] vec);
        cnt = 0; vec = 8'h0;
        @(negedge clk);
        irq_in[line] = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (req_valid) begin cnt++; vec = req_vector; end
        end
        irq_in[line] = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int          cnt;
        logic [7:0]  vec;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: reset state
        check(req_valid == 1'b0, "R5 no request after reset", {31'h0, req_valid}, 32'h0);
        bus_read(8'h00, d);
        check(d == 32'h0, "R5 selector reset", d, 32'h0);
        reg_read(8'h00, d);
        check(d == 32'h0, "R5 identifier reset", d, 32'h0);
        reg_read(8'h1A, d);
        check(d == 32'h0001_0000, "R5 low word reset (line 5)", d, 32'h0001_0000);
        reg_read(8'h1B, d);
        check(d == 32'h0, "R5 high word reset (line 5)", d, 32'h0);
        reg_read(8'h3E, d);
        check(d == 32'h0001_0000, "R5 low word reset (line 23)", d, 32'h0001_0000);

        // R3: version and arbitration registers
        reg_read(8'h01, d);
        check(d == 32'h0017_0011, "R3 version word", d, 32'h0017_0011);
        reg_write(8'h01, 32'hFFFF_FFFF);
        reg_read(8'h01, d);
        check(d == 32'h0017_0011, "R3 version write ignored", d, 32'h0017_0011);
        reg_write(8'h02, 32'h0F00_0000);
        reg_read(8'h02, d);
        check(d == 32'h0, "R3 arbitration reads zero", d, 32'h0);

        // R2: identifier
        reg_write(8'h00, 32'hAB12_3456);
        reg_read(8'h00, d);
        check(d == 32'hAB00_0000, "R2 identifier readback", d, 32'hAB00_0000);

        // R8: undefined internal registers
        reg_write(8'h03, 32'h1234_5678);
        reg_read(8'h03, d);
        check(d == 32'h0, "R8 register 0x03 reads zero", d, 32'h0);
        reg_write(8'h40, 32'h0000_0042);
        reg_read(8'h40, d);
        check(d == 32'h0, "R8 register 0x40 reads zero", d, 32'h0);
        reg_read(8'h3E, d);
        check(d == 32'h0001_0000, "R8 write to 0x40 left line 23 alone", d, 32'h0001_0000);

        // R1: unused offsets
        bus_write(8'h00, 32'h0000_0011);
        bus_write(8'h04, 32'h0000_0007);
        bus_read(8'h00, d);
        check(d == 32'h11, "R1 write to offset 0x04 ignored", d, 32'h11);
        bus_read(8'h04, d);
        check(d == 32'h0, "R1 offset 0x04 reads zero", d, 32'h0);
        bus_read(8'h14, d);
        check(d == 32'h0, "R1 offset 0x14 reads zero", d, 32'h0);

        // R4, R6, R7: vector table
        foreach (VECS[i]) begin
            reg_write(8'h10 + 8'(2 * VECS[i].line), VECS[i].low);
            reg_read(8'h10 + 8'(2 * VECS[i].line), d);
            check(d == VECS[i].low, "R4 low word readback", d, VECS[i].low);
            pulse(int'(VECS[i].line), cnt, vec);
            check(cnt == int'(VECS[i].exp_cnt), "R6/R7 request count", 32'(cnt), 32'(VECS[i].exp_cnt));
            if (VECS[i].exp_cnt != 0)
                check(vec == VECS[i].exp_vec, "R6 request vector", {24'h0, vec}, {24'h0, VECS[i].exp_vec});
        end

        // R11: field decode, high word readback
        reg_write(8'h22, 32'h0000_8D42);
        reg_write(8'h23, 32'h5A00_0000);
        reg_read(8'h23, d);
        check(d == 32'h5A00_0000, "R4 high word readback", d, 32'h5A00_0000);
        @(negedge clk);
        irq_in[9] = 1'b1;
        repeat (2) @(negedge clk);
        check(req_valid == 1'b1, "R6 request on second edge", {31'h0, req_valid}, 32'h1);
        check({req_vector, req_dmode, req_logical, req_level, req_dest} == {8'h42, 3'd5, 1'b1, 1'b1, 8'h5A},
              "R11 decoded fields",
              {5'h0, req_dmode, req_logical, req_level, req_dest, req_vector}, {5'h0, 3'd5, 2'b11, 8'h5A, 8'h42});
        @(negedge clk);
        check(req_valid == 1'b0, "R6 one-cycle request", {31'h0, req_valid}, 32'h0);
        irq_in[9] = 1'b0;
        repeat (2) @(negedge clk);

        // R9, R10: simultaneous edges with stalled port
        reg_write(8'h16, 32'h0000_0033);
        reg_write(8'h1E, 32'h0000_0077);
        req_ready = 1'b0;
        @(negedge clk);
        irq_in[3] = 1'b1; irq_in[7] = 1'b1;
        repeat (4) @(negedge clk);
        check(req_valid && req_vector == 8'h33, "R9 lowest line first", {24'h0, req_vector}, 32'h33);
        repeat (3) @(negedge clk);
        check(req_valid && req_vector == 8'h33, "R10 held while stalled", {24'h0, req_vector}, 32'h33);
        req_ready = 1'b1;
        @(negedge clk);
        check(req_valid && req_vector == 8'h77, "R9 pending line issued next", {24'h0, req_vector}, 32'h77);
        @(negedge clk);
        check(req_valid == 1'b0, "R9 queue drained", {31'h0, req_valid}, 32'h0);
        irq_in = '0;
        repeat (2) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule